// File: doc/BRIEF.md
# Page Write Cache Flusher

This block buffers a host write burst between a serial-bus slave and a page-programmed nonvolatile array. While the host is sending, each byte is stored in a small cache at bus speed. The cache holds eight pages of eight bytes each. When the host ends the transfer, the block empties the cache into the array. It writes one array page at a time, and each page program is followed by a self-timed write cycle whose length is a parameter in clock cycles.

The first byte of a burst fixes two things. Its address picks the array page that receives cache page 0, and its low bits give the starting byte position inside that page. Later bytes fill consecutive cache positions, and a burst longer than the cache wraps around to the start of the cache. Cache page p is written to the array page that lies p pages after the start page. Each program carries a byte-enable mask, so bytes the host did not send keep their old array contents. A protection verdict comes in with the stop event. It can veto the whole burst, and the block then discards it.

Top module: `page_cache_flusher`

## Requirements
- R1: After reset, `busy` and `arr_we` are low and the cache is empty.
- R2: A byte accepted while the cache is empty starts a burst. Array page `wr_addr[ADDR_W-1:3]` becomes the start page, and the byte lands at cache position `wr_addr[2:0]`. Each later accepted byte goes to the next cache position, and its `wr_addr` is ignored.
- R3: The cache holds 64 byte positions. After position 63 the next byte goes to position 0, and a later byte replaces an earlier one at the same position.
- R4: A stop event with a non-empty cache and `wr_veto` low raises `busy`. The first `arr_we` pulse appears in the cycle right after the cycle in which the stop was sampled.
- R5: Cache pages that hold at least one byte are programmed in ascending order. Cache page p goes to `arr_page` = (start page + p) modulo 2^(ADDR_W-3). Pages with no bytes produce no pulse.
- R6: For each pulse, bit b of `arr_bmask` is set exactly when byte b of that cache page was written. `arr_wdata[8b+7:8b]` then carries the last value written there.
- R7: Each `arr_we` pulse lasts one cycle. The next pulse follows exactly WR_CYCLES+1 cycles after the previous one. `busy` is low exactly WR_CYCLES+1 cycles after the last pulse of the burst.
- R8: A byte strobe while `busy` is high changes nothing: neither the cache contents nor any page programmed later in the same flush.
- R9: A stop event with `wr_veto` high discards the collected bytes. No pulse follows, `busy` stays low, and the next byte starts a new burst.
- R10: A stop event with an empty cache leaves `busy` low and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | One-cycle strobe: a data byte from the protocol block |
| wr_addr | input | ADDR_W | Byte address of the strobe (used only for a burst's first byte) |
| wr_data | input | DATA_W | Byte value |
| stop_evt | input | 1 | One-cycle pulse: host ended the transfer |
| wr_veto | input | 1 | Protection verdict, valid with `stop_evt`; high discards the burst |
| busy | output | 1 | High from an accepted stop until the last write cycle ends |
| arr_we | output | 1 | One-cycle page program strobe |
| arr_page | output | ADDR_W-3 | Array page number being programmed |
| arr_wdata | output | 8*DATA_W | Page data, byte b at bits [8b+DATA_W-1 : 8b] scaled by DATA_W |
| arr_bmask | output | 8 | Byte enables for the programmed page |

## Verification
The embedded properties assume that the protocol block never asserts `wr_valid` and `stop_evt` in the same cycle, and that `wr_veto` is only meaningful during a `stop_evt` cycle. The stimulus keeps to both rules. Each byte is driven as a lone one-cycle strobe with an idle cycle after it, and every stop is a separate one-cycle pulse with the veto level set beside it. Bytes sent during a flush are aimed at a cache page that is still waiting to be programmed, so any leak of a refused byte would show up in a later program mask.

// File: rtl/pwc_pkg.sv
// Package: shared types of the page write cache flusher.
// Assumes: nothing beyond IEEE 1800-2017.
package pwc_pkg;
    // Flush controller phases: collecting bytes, one program strobe, timed wait.
    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_PROG    = 2'd1,
        ST_WAIT    = 2'd2
    } flush_state_t;
endpackage

// File: rtl/pwc_cache_store.sv
// Module: pwc_cache_store
// Byte-wide cache of CACHE_PAGES pages of PAGE_BYTES bytes, with one valid bit
// per byte and an internal fill pointer that wraps at the end of the cache.
// Presents one whole page (data plus valid mask) selected by rd_sel.
// Assumes: PAGE_BYTES and CACHE_PAGES are powers of two; wr_en and clear are
// never high in the same cycle.
module pwc_cache_store #(
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 8,
    parameter int CACHE_PAGES = 8,
    localparam int OFF_W       = $clog2(PAGE_BYTES),
    localparam int PSEL_W      = $clog2(CACHE_PAGES),
    localparam int CACHE_BYTES = PAGE_BYTES * CACHE_PAGES,
    localparam int PTR_W       = $clog2(CACHE_BYTES)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic                         wr_first,
    input  logic [OFF_W-1:0]             start_off,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         clear,
    input  logic [PSEL_W-1:0]            rd_sel,
    output logic [PAGE_BYTES*DATA_W-1:0] rd_data,
    output logic [PAGE_BYTES-1:0]        rd_mask,
    output logic [CACHE_PAGES-1:0]       page_used,
    output logic                         empty
);
    logic [DATA_W-1:0]      mem [CACHE_BYTES];
    logic [CACHE_BYTES-1:0] valid;
    logic [PTR_W-1:0]       ptr;
    logic [PTR_W-1:0]       idx;
    logic [PTR_W-1:0]       rd_base;

    // Position of the incoming byte: page offset for a new burst, else the pointer (R2).
    assign idx = wr_first ? PTR_W'(start_off) : ptr;

    // Valid bits and fill pointer; the increment wraps naturally at the end (R3).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= '0;
            ptr   <= '0;
        end else if (clear) begin
            valid <= '0;
            ptr   <= '0;
        end else if (wr_en) begin
            valid[idx] <= 1'b1;
            ptr        <= idx + PTR_W'(1);
        end
    end

    // Byte storage, no reset needed since validity lives in the valid bits.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[idx] <= wr_data;
        end
    end

    assign empty   = ~|valid;
    assign rd_base = {rd_sel, {OFF_W{1'b0}}};

    // Per-page occupancy summary.
    for (genvar g = 0; g < CACHE_PAGES; g++) begin : g_page_used
        assign page_used[g] = |valid[g*PAGE_BYTES +: PAGE_BYTES];
    end

    // Read mux of the selected page.
    always_comb begin
        for (int b = 0; b < PAGE_BYTES; b++) begin
            rd_data[b*DATA_W +: DATA_W] = mem[rd_base + PTR_W'(b)];
        end
        rd_mask = valid[rd_base +: PAGE_BYTES];
    end
endmodule

// File: rtl/pwc_page_picker.sv
// Module: pwc_page_picker
// Returns the lowest-numbered set bit of the pending page vector.
// Assumes: the caller ignores sel while pending is all zero.
module pwc_page_picker #(
    parameter int CACHE_PAGES = 8,
    localparam int PSEL_W = $clog2(CACHE_PAGES)
) (
    input  logic [CACHE_PAGES-1:0] pending,
    output logic [PSEL_W-1:0]      sel
);
    // Priority scan from the top so that the lowest pending page wins (R5).
    always_comb begin
        sel = '0;
        for (int i = CACHE_PAGES - 1; i >= 0; i--) begin
            if (pending[i]) begin
                sel = PSEL_W'(i);
            end
        end
    end
endmodule

// File: rtl/pwc_prog_timer.sv
// Module: pwc_prog_timer
// Down-counter for the self-timed write cycle; done is high when it sits at zero.
// Assumes: WR_CYCLES >= 1.
module pwc_prog_timer #(
    parameter int WR_CYCLES = 500000,
    localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    logic [CNT_W-1:0] count;

    // Load the cycle length minus one, then count down and hold at zero (R7).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= CNT_W'(WR_CYCLES - 1);
        end else if (count != '0) begin
            count <= count - CNT_W'(1);
        end
    end

    assign done = (count == '0);
endmodule

// File: rtl/pwc_flush_ctrl.sv
// Module: pwc_flush_ctrl
// Flush sequencer: snapshots the used pages at stop, then alternates one program
// strobe with a timed wait per pending page, and clears the cache when done.
// Assumes: stop_evt is a one-cycle pulse; wr_veto is valid with it.
module pwc_flush_ctrl
    import pwc_pkg::*;
#(
    parameter int CACHE_PAGES = 8,
    localparam int PSEL_W = $clog2(CACHE_PAGES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stop_evt,
    input  logic                   wr_veto,
    input  logic                   cache_empty,
    input  logic [CACHE_PAGES-1:0] page_used,
    input  logic [PSEL_W-1:0]      sel,
    input  logic                   timer_done,
    output logic [CACHE_PAGES-1:0] pending,
    output logic                   busy,
    output logic                   prog,
    output logic                   timer_load,
    output logic                   clear_cache
);
    flush_state_t state;
    logic         go;

    // A stop starts a flush only with bytes present and no veto (R4, R9, R10).
    assign go = stop_evt && !wr_veto && !cache_empty;

    // Phase register and the pending-page vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_COLLECT;
            pending <= '0;
        end else begin
            case (state)
                ST_COLLECT: begin
                    if (go) begin
                        pending <= page_used;
                        state   <= ST_PROG;
                    end
                end
                ST_PROG: begin
                    pending[sel] <= 1'b0;
                    state        <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (timer_done) begin
                        state <= (pending == '0) ? ST_COLLECT : ST_PROG;
                    end
                end
                default: state <= ST_COLLECT;
            endcase
        end
    end

    // Decoded outputs of the phase.
    always_comb begin
        busy        = (state != ST_COLLECT);
        prog        = (state == ST_PROG);
        timer_load  = (state == ST_PROG);
        clear_cache = ((state == ST_COLLECT) && stop_evt && wr_veto)
                   || ((state == ST_WAIT) && timer_done && (pending == '0));
    end

    // R7: a program strobe never lasts two cycles.
    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        prog |=> !prog);

    // R7: the wait phase is held until the timer expires.
    a_r7_wait_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && !timer_done) |=> (state == ST_WAIT));

    // R4: an accepted stop leads straight to a program strobe.
    a_r4_prog_follows_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_evt && !wr_veto && !cache_empty) |=> prog);

    // R9: a vetoed stop keeps the block idle.
    a_r9_veto_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_evt && wr_veto) |=> !busy);

    // R10: a stop with nothing collected keeps the block idle.
    a_r10_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && stop_evt && cache_empty) |=> !busy);

    // R5: busy only drops once every pending page has been programmed.
    a_r5_all_pages_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(pending) == '0));
endmodule

// File: rtl/page_cache_flusher.sv
// Module: page_cache_flusher (top)
// Collects a host write burst in a paged byte cache and, on stop, programs the
// used cache pages into consecutive array pages, each followed by a timed cycle.
// Assumes: wr_valid and stop_evt are never high together; PAGE_BYTES and
// CACHE_PAGES are powers of two; WR_CYCLES >= 1.
module page_cache_flusher #(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 8,
    parameter int CACHE_PAGES = 8,
    parameter int WR_CYCLES   = 500000,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PSEL_W     = $clog2(CACHE_PAGES),
    localparam int PAGE_NUM_W = ADDR_W - OFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_valid,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         stop_evt,
    input  logic                         wr_veto,
    output logic                         busy,
    output logic                         arr_we,
    output logic [PAGE_NUM_W-1:0]        arr_page,
    output logic [PAGE_BYTES*DATA_W-1:0] arr_wdata,
    output logic [PAGE_BYTES-1:0]        arr_bmask
);
    logic                   accept;
    logic                   cache_empty;
    logic                   clear_cache;
    logic                   timer_load;
    logic                   timer_done;
    logic                   prog;
    logic [PSEL_W-1:0]      sel;
    logic [CACHE_PAGES-1:0] page_used;
    logic [CACHE_PAGES-1:0] pending;
    logic [PAGE_NUM_W-1:0]  start_page;

    // Bytes are taken only while idle and outside a stop cycle (R8).
    assign accept = wr_valid && !busy && !stop_evt;

    // Start page of the burst, taken from the first accepted byte (R2).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_page <= '0;
        end else if (accept && cache_empty) begin
            start_page <= wr_addr[ADDR_W-1:OFF_W];
        end
    end

    pwc_cache_store #(
        .DATA_W      (DATA_W),
        .PAGE_BYTES  (PAGE_BYTES),
        .CACHE_PAGES (CACHE_PAGES)
    ) u_cache (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .wr_first  (cache_empty),
        .start_off (wr_addr[OFF_W-1:0]),
        .wr_data   (wr_data),
        .clear     (clear_cache),
        .rd_sel    (sel),
        .rd_data   (arr_wdata),
        .rd_mask   (arr_bmask),
        .page_used (page_used),
        .empty     (cache_empty)
    );

    pwc_page_picker #(
        .CACHE_PAGES (CACHE_PAGES)
    ) u_picker (
        .pending (pending),
        .sel     (sel)
    );

    pwc_prog_timer #(
        .WR_CYCLES (WR_CYCLES)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (timer_load),
        .done  (timer_done)
    );

    pwc_flush_ctrl #(
        .CACHE_PAGES (CACHE_PAGES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_evt    (stop_evt),
        .wr_veto     (wr_veto),
        .cache_empty (cache_empty),
        .page_used   (page_used),
        .sel         (sel),
        .timer_done  (timer_done),
        .pending     (pending),
        .busy        (busy),
        .prog        (prog),
        .timer_load  (timer_load),
        .clear_cache (clear_cache)
    );

    // Array write port: page number offset from the start page, wrapping (R5).
    assign arr_we   = prog;
    assign arr_page = start_page + PAGE_NUM_W'(sel);

    // R6: every program strobe carries at least one enabled byte.
    a_r6_mask_live: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (arr_bmask != '0));

    // R8: cache occupancy is frozen during a flush until the final clear.
    a_r8_cache_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clear_cache) |=> $stable(page_used));
endmodule

// File: tb/page_cache_flusher_tb.sv
module page_cache_flusher_tb;
    localparam int WR     = 12;
    localparam int ADDR_W = 13;
    localparam int PN_W   = 10;

    typedef struct packed {
        logic [PN_W-1:0] page;
        logic [7:0]      mask;
        logic [63:0]     data;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [12:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        stop_evt = 1'b0;
    logic        wr_veto = 1'b0;
    logic        busy;
    logic        arr_we;
    logic [9:0]  arr_page;
    logic [63:0] arr_wdata;
    logic [7:0]  arr_bmask;

    int     n_cmp = 0;
    int     n_bad = 0;
    longint cyc = 0;
    longint stop_cyc = 0;
    longint last_pulse = 0;
    bit     first_pulse = 1'b0;
    bit     prev_busy = 1'b0;
    exp_t   exp_q[$];

    // Reference cache model kept by the driver side.
    logic [7:0]      m_data [64];
    logic [63:0]     m_val = '0;
    int              m_ptr = 0;
    logic [PN_W-1:0] m_start = '0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    page_cache_flusher #(.WR_CYCLES(WR)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .stop_evt(stop_evt), .wr_veto(wr_veto),
        .busy(busy), .arr_we(arr_we), .arr_page(arr_page),
        .arr_wdata(arr_wdata), .arr_bmask(arr_bmask)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] widen(input logic [7:0] m);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[b*8 +: 8] = {8{m[b]}};
        return r;
    endfunction

    // Driver: one accepted byte, model updated per R2/R3.
    task automatic put_byte(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        if (m_val == '0) begin
            m_start = a[12:3];
            m_ptr   = int'(a[2:0]);
        end
        m_data[m_ptr] = d;
        m_val[m_ptr]  = 1'b1;
        m_ptr = (m_ptr + 1) % 64;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Driver: a byte the design must refuse (R8); model untouched.
    task automatic poke_byte(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    // Driver: stop event; pushes expected page programs into the scoreboard.
    task automatic send_stop(input bit veto);
        exp_t it;
        @(negedge clk);
        stop_evt = 1'b1; wr_veto = veto;
        if (m_val != '0 && !veto) begin
            stop_cyc    = cyc;
            first_pulse = 1'b1;
            for (int p = 0; p < 8; p++) begin
                if (m_val[p*8 +: 8] != '0) begin
                    it.page = m_start + PN_W'(p);
                    it.mask = m_val[p*8 +: 8];
                    for (int b = 0; b < 8; b++) it.data[b*8 +: 8] = m_data[p*8 + b];
                    exp_q.push_back(it);
                end
            end
        end
        m_val = '0;
        m_ptr = 0;
        @(negedge clk);
        stop_evt = 1'b0; wr_veto = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pops expected programs and checks content and timing.
    always @(negedge clk) begin
        if (rst_n) begin
            if (arr_we) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5", "unexpected program strobe", 64'(arr_page), 64'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(arr_page == e.page, "R2 R5", "array page", 64'(arr_page), 64'(e.page));
                    check(arr_bmask == e.mask, "R6", "byte mask", 64'(arr_bmask), 64'(e.mask));
                    check((arr_wdata & widen(e.mask)) == (e.data & widen(e.mask)),
                          "R3 R6", "page data", arr_wdata & widen(e.mask), e.data & widen(e.mask));
                    check(busy, "R4", "busy during program", 64'(busy), 64'h1);
                    if (first_pulse)
                        check(cyc == stop_cyc + 1, "R4", "first strobe cycle",
                              64'(cyc), 64'(stop_cyc + 1));
                    else
                        check(cyc == last_pulse + WR + 1, "R7", "strobe spacing",
                              64'(cyc), 64'(last_pulse + WR + 1));
                    first_pulse = 1'b0;
                    last_pulse  = cyc;
                end
            end
            if (prev_busy && !busy) begin
                check(cyc == last_pulse + WR + 1, "R7", "busy release cycle",
                      64'(cyc), 64'(last_pulse + WR + 1));
                check(exp_q.size() == 0, "R5", "pages left at release",
                      64'(exp_q.size()), 64'h0);
            end
            prev_busy = busy;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (60000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", 64'(busy), 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && arr_we == 1'b0, "R1", "idle after reset",
              64'({busy, arr_we}), 64'h0);

        // Single byte mid-page.
        put_byte(13'h0105, 8'hA5);
        send_stop(1'b0);
        wait_idle();

        // 20 bytes crossing the top of the array (page wrap, R5).
        for (int i = 0; i < 20; i++) put_byte(13'h1FFB + 13'(i), 8'(i * 3 + 1));
        send_stop(1'b0);
        wait_idle();

        // 70 bytes: cache wraps and overwrites its first positions (R3).
        for (int i = 0; i < 70; i++) put_byte(13'h0202, 8'(i + 8'h40));
        send_stop(1'b0);
        wait_idle();

        // R8: refused byte during flush would land in cache page 1.
        for (int i = 0; i < 9; i++) put_byte(13'h0300, 8'(8'h90 + i));
        send_stop(1'b0);
        repeat (3) @(negedge clk);
        poke_byte(13'h0777, 8'h5E);
        wait_idle();

        // R9: vetoed burst leaves nothing behind.
        for (int i = 0; i < 5; i++) put_byte(13'h0400, 8'(8'h20 + i));
        send_stop(1'b1);
        repeat (3) begin
            check(busy == 1'b0, "R9", "busy after veto", 64'(busy), 64'h0);
            @(negedge clk);
        end
        put_byte(13'h0011, 8'h3C);
        send_stop(1'b0);
        wait_idle();

        // R10: stop with an empty cache.
        send_stop(1'b0);
        repeat (2) begin
            check(busy == 1'b0, "R10", "busy after empty stop", 64'(busy), 64'h0);
            @(negedge clk);
        end
        repeat (WR + 4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule